// File: doc/BRIEF.md
# Branch Target Buffer with Selectable Two-Bit Hysteresis

This block predicts the next fetch address. It holds a small direct-mapped table. The low-order word bits of the fetch address select one entry. Each entry keeps a valid flag, the upper address bits of the branch that owns it, that branch's target and two history bits. The lookup is combinational. When the entry is valid, its tag matches the fetch address and its history predicts taken, the stored target becomes the next fetch address. In every other case the next address is the fetch address plus four.

Resolved branches come back through an update port. Each update carries the branch address, its target and whether it was taken, and the entry changes on the following clock edge. A mode input chooses the history scheme. In one-bit mode the prediction follows the last outcome. In two-bit mode the prediction has hysteresis: it must be wrong twice in a row before it changes direction. The block only reports its prediction. Recovery from a wrong prediction is left to the pipeline that uses it.

Top module: `btb_predictor`

## Requirements
- R1: After reset no entry is valid, so every lookup reports predHit=0 and predTaken=0, and nextPc equals fetchPc+4.
- R2: predHit is 1 when the entry selected by fetchPc is valid and its tag equals fetchPc[31:6]. predTaken is 1 only when predHit is 1 and the history predicts taken. nextPc is the stored target when predTaken is 1, and fetchPc+4 otherwise.
- R3: The entry index is PC bits [5:2] (16 entries). A lookup whose tag differs from the stored one misses. An update from a branch with a different tag at the same index replaces that entry, and the replaced branch then misses.
- R4: An update that misses allocates the entry. In two-bit mode a taken outcome starts the entry in the weakly-taken state 10, and a not-taken outcome starts it in the strongly-not-taken state 00.
- R5: In one-bit mode every update sets the history so that the next lookup of that branch predicts exactly the outcome just reported.
- R6: In two-bit mode an update that hits moves the history as follows. States 11 and 10 predict taken; states 01 and 00 predict not taken.
  - From 11: taken stays in 11; not taken goes to 10.
  - From 10: taken goes to 11; not taken goes to 00.
  - From 00: taken goes to 01; not taken stays in 00.
  - From 01: taken goes to 11; not taken goes to 00.
- R7: When a lookup and an update address the same entry in one cycle, the lookup sees the contents from before the update. The update is visible from the next cycle on.
- R8: Every update writes the reported target into the entry. An entry that hits therefore predicts the most recently reported target.
- R9: Take a loop branch that is taken nine times and then not taken, run a second time. On the second run it is mispredicted twice in one-bit mode and once in two-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| twoBitMode | input | 1 | 1 selects two-bit hysteresis history, 0 selects one-bit history |
| fetchPc | input | 32 | Address being fetched |
| updValid | input | 1 | A resolved branch is reported this cycle |
| updPc | input | 32 | Address of the resolved branch |
| updTarget | input | 32 | Target of the resolved branch |
| updTaken | input | 1 | Outcome of the resolved branch |
| nextPc | output | 32 | Predicted next fetch address |
| predHit | output | 1 | Lookup found a valid entry with a matching tag |
| predTaken | output | 1 | Lookup hit and predicts taken |

## Verification
In two-bit mode a single branch is walked through every history state, with both outcomes from each state. Because the states 10 and 01 cannot be seen at the ports, each one is identified by the prediction that follows the next outcome. Two branches that share one index separate the tag compare from the index selection, and an update of a branch that already hits, carrying a new target, separates a target refresh from a plain history update. A lookup in the same cycle as its own update tells the read-before-write order apart from bypassing. A repeated ten-iteration loop in each mode distinguishes one-bit tracking from hysteresis by the number of wrong predictions.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef logic [1:0] hist_t;

  localparam hist_t HIST_STRONG_NT = 2'b00;
  localparam hist_t HIST_WEAK_NT   = 2'b01;
  localparam hist_t HIST_WEAK_T    = 2'b10;
  localparam hist_t HIST_STRONG_T  = 2'b11;

  // strobes from the control to the datapath
  typedef struct packed {
    logic  wrEn;
    logic  alloc;
    hist_t newHist;
  } btb_ctrl_t;

endpackage

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
(
  input  logic      updValid,
  input  logic      updTaken,
  input  logic      twoBitMode,
  input  logic      updHit,
  input  hist_t     updHist,
  output btb_ctrl_t ctrl
);

  hist_t nextHist;

  always_comb begin
    if (!twoBitMode) begin
      nextHist = updTaken ? HIST_STRONG_T : HIST_STRONG_NT;
    end else if (!updHit) begin
      nextHist = updTaken ? HIST_WEAK_T : HIST_STRONG_NT;
    end else begin
      unique case (updHist)
        HIST_STRONG_T:  nextHist = updTaken ? HIST_STRONG_T : HIST_WEAK_T;
        HIST_WEAK_T:    nextHist = updTaken ? HIST_STRONG_T : HIST_STRONG_NT;
        HIST_WEAK_NT:   nextHist = updTaken ? HIST_STRONG_T : HIST_STRONG_NT;
        default:        nextHist = updTaken ? HIST_WEAK_NT  : HIST_STRONG_NT;
      endcase
    end
  end

  always_comb begin
    ctrl.wrEn    = updValid;
    ctrl.alloc   = updValid && !updHit;
    ctrl.newHist = nextHist;
  end

endmodule

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int OFF_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  input  logic [PC_W-1:0] updPc,
  input  logic [PC_W-1:0] updTarget,
  input  btb_ctrl_t       ctrl,
  output logic            updHit,
  output hist_t           updHist,
  output logic [PC_W-1:0] nextPc,
  output logic            predHit,
  output logic            predTaken
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - OFF_W;
  localparam int TAG_LSB = IDX_W + OFF_W;

  logic [DEPTH-1:0] validQ;
  logic [TAG_W-1:0] tagQ [DEPTH];
  logic [PC_W-1:0]  tgtQ [DEPTH];
  hist_t            histQ[DEPTH];

  logic [IDX_W-1:0] fetchIdx, updIdx;
  logic [TAG_W-1:0] fetchTag, updTag;

  assign fetchIdx = fetchPc[TAG_LSB-1:OFF_W];
  assign fetchTag = fetchPc[PC_W-1:TAG_LSB];
  assign updIdx   = updPc[TAG_LSB-1:OFF_W];
  assign updTag   = updPc[PC_W-1:TAG_LSB];

  // per-entry match vectors for both read ports
  logic [DEPTH-1:0] fetchMatch, updMatch;
  for (genvar e = 0; e < DEPTH; e++) begin : g_match
    assign fetchMatch[e] = validQ[e] && (tagQ[e] == fetchTag) && (fetchIdx == IDX_W'(e));
    assign updMatch[e]   = validQ[e] && (tagQ[e] == updTag)   && (updIdx   == IDX_W'(e));
  end

  assign predHit   = |fetchMatch;
  assign predTaken = predHit && histQ[fetchIdx][1];
  assign nextPc    = predTaken ? tgtQ[fetchIdx] : fetchPc + PC_W'(4);

  assign updHit  = |updMatch;
  assign updHist = histQ[updIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (ctrl.wrEn) begin
      validQ[updIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.wrEn) begin
      tagQ[updIdx]  <= updTag;
      tgtQ[updIdx]  <= updTarget;
      histQ[updIdx] <= ctrl.newHist;
    end
  end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            twoBitMode,
  input  logic [PC_W-1:0] fetchPc,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic [PC_W-1:0] updTarget,
  input  logic            updTaken,
  output logic [PC_W-1:0] nextPc,
  output logic            predHit,
  output logic            predTaken
);

  btb_ctrl_t ctrl;
  logic      updHit;
  hist_t     updHist;

  btb_ctrl u_ctrl (
    .updValid  (updValid),
    .updTaken  (updTaken),
    .twoBitMode(twoBitMode),
    .updHit    (updHit),
    .updHist   (updHist),
    .ctrl      (ctrl)
  );

  btb_datapath #(
    .PC_W (PC_W),
    .IDX_W(IDX_W),
    .OFF_W(2)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .fetchPc  (fetchPc),
    .updPc    (updPc),
    .updTarget(updTarget),
    .ctrl     (ctrl),
    .updHit   (updHit),
    .updHist  (updHist),
    .nextPc   (nextPc),
    .predHit  (predHit),
    .predTaken(predTaken)
  );

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            twoBitMode,
  input logic [PC_W-1:0] fetchPc,
  input logic            updValid,
  input logic [PC_W-1:0] updPc,
  input logic [PC_W-1:0] updTarget,
  input logic            updTaken,
  input logic [PC_W-1:0] nextPc,
  input logic            predHit,
  input logic            predTaken
);

  p_taken_needs_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
    predTaken |-> predHit);

  p_fallthrough_r2: assert property (@(posedge clk) disable iff (!rstN)
    !predTaken |-> (nextPc == fetchPc + PC_W'(4)));

  p_update_allocates_r3: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> ((fetchPc != $past(updPc)) || predHit));

  p_onebit_taken_r5: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updTaken && !twoBitMode) |=>
      ((fetchPc != $past(updPc)) || (predTaken && nextPc == $past(updTarget))));

  p_onebit_not_taken_r5: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updTaken && !twoBitMode) |=>
      ((fetchPc != $past(updPc)) || !predTaken));

endmodule

bind btb_predictor btb_predictor_chk #(.PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .twoBitMode(twoBitMode),
  .fetchPc   (fetchPc),
  .updValid  (updValid),
  .updPc     (updPc),
  .updTarget (updTarget),
  .updTaken  (updTaken),
  .nextPc    (nextPc),
  .predHit   (predHit),
  .predTaken (predTaken)
);

// File: tb/btb_predictor_bench.sv
module btb_predictor_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        twoBitMode = 1'b1;
  logic [31:0] fetchPc = '0;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic [31:0] updTarget = '0;
  logic        updTaken = 1'b0;
  logic [31:0] nextPc;
  logic        predHit, predTaken;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  btb_predictor u_btb_predictor (
    .clk(clk), .rstN(rstN), .twoBitMode(twoBitMode), .fetchPc(fetchPc),
    .updValid(updValid), .updPc(updPc), .updTarget(updTarget), .updTaken(updTaken),
    .nextPc(nextPc), .predHit(predHit), .predTaken(predTaken)
  );

  typedef struct {
    logic        hit;
    logic        tk;
    logic [31:0] nxt;
    string       req;
  } exp_t;

  exp_t expQ[$];

  // monitor: compares at the falling edge, away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (predHit !== e.hit || predTaken !== e.tk || nextPc !== e.nxt) begin
        errors++;
        $display("FAIL %s: got hit=%b tk=%b next=%h, expected hit=%b tk=%b next=%h",
                 e.req, predHit, predTaken, nextPc, e.hit, e.tk, e.nxt);
      end
    end
  end

  // driver: one cycle of lookup plus optional update
  task automatic cyc(input logic [31:0] pc, input logic uv, input logic [31:0] upc,
                     input logic [31:0] utg, input logic utk,
                     input logic eHit, input logic eTk, input logic [31:0] eTgt,
                     input string req);
    exp_t e;
    fetchPc = pc; updValid = uv; updPc = upc; updTarget = utg; updTaken = utk;
    e.hit = eHit; e.tk = eTk; e.nxt = eTk ? eTgt : pc + 32'd4; e.req = req;
    expQ.push_back(e);
    @(posedge clk); #1;
    updValid = 1'b0;
  endtask

  task automatic upd(input logic [31:0] upc, input logic [31:0] utg, input logic utk);
    fetchPc = 32'h0; updValid = 1'b1; updPc = upc; updTarget = utg; updTaken = utk;
    @(posedge clk); #1;
    updValid = 1'b0;
  endtask

  task automatic look(input logic [31:0] pc, input logic eHit, input logic eTk,
                      input logic [31:0] eTgt, input string req);
    cyc(pc, 1'b0, 32'h0, 32'h0, 1'b0, eHit, eTk, eTgt, req);
  endtask

  // runs a ten-iteration loop twice, returns mispredictions of the second run
  task automatic runLoop(input logic [31:0] pc, input logic [31:0] tgt, output int miss);
    miss = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 10; i++) begin
        logic outcome;
        outcome = (i < 9);
        fetchPc = pc; updValid = 1'b1; updPc = pc; updTarget = tgt; updTaken = outcome;
        @(negedge clk); #1;
        if (pass == 1 && predTaken !== outcome) miss++;
        @(posedge clk); #1;
        updValid = 1'b0;
      end
    end
  endtask

  localparam logic [31:0] PA  = 32'h1000_0040;
  localparam logic [31:0] PB  = 32'h1000_0080;
  localparam logic [31:0] PC2 = 32'h2000_000C;
  localparam logic [31:0] PC3 = 32'h3000_0014;
  localparam logic [31:0] T1  = 32'h0000_8000;
  localparam logic [31:0] T2  = 32'h0000_9000;

  initial begin
    int m;
    repeat (2) @(posedge clk);
    #1;
    look(32'h0000_0100, 0, 0, 0, "R1 reset miss");
    rstN = 1'b1;
    @(posedge clk); #1;
    look(PA, 0, 0, 0, "R1 empty after reset");

    // two-bit mode, same-cycle read and allocation
    twoBitMode = 1'b1;
    cyc(PA, 1, PA, T1, 1, 0, 0, 0, "R7 same-cycle lookup sees old entry");
    look(PA, 1, 1, T1, "R4 taken alloc predicts taken");
    upd(PA, T1, 0);
    look(PA, 1, 0, 0, "R4 alloc was weak taken 10 -> 00");
    upd(PA, T1, 1);
    look(PA, 1, 0, 0, "R6 00 taken -> 01 not taken");
    upd(PA, T1, 0);
    look(PA, 1, 0, 0, "R6 01 not taken -> 00");
    upd(PA, T1, 1);
    upd(PA, T1, 1);
    look(PA, 1, 1, T1, "R6 01 taken -> 11");
    upd(PA, T1, 1);
    look(PA, 1, 1, T1, "R6 11 taken stays 11");
    upd(PA, T1, 0);
    look(PA, 1, 1, T1, "R6 11 not taken -> 10 still taken");
    upd(PA, T1, 1);
    upd(PA, T1, 0);
    look(PA, 1, 1, T1, "R6 10 taken -> 11");
    upd(PA, T1, 0);
    look(PA, 1, 0, 0, "R6 10 not taken -> 00");

    // index aliasing
    upd(PA, T1, 1);
    look(PB, 0, 0, 0, "R3 same index other tag misses");
    look(PA, 1, 0, 0, "R2 hit but not-taken gives pc+4");
    upd(PB, T2, 0);
    look(PB, 1, 0, 0, "R4 not-taken alloc predicts not taken");
    look(PA, 0, 0, 0, "R3 replaced branch misses");
    upd(PB, T2, 1);
    look(PB, 1, 0, 0, "R4 not-taken alloc was 00 (now 01)");

    // target refresh
    upd(PC2, T1, 1);
    upd(PC2, T2, 1);
    look(PC2, 1, 1, T2, "R8 latest target used");

    // one-bit mode
    twoBitMode = 1'b0;
    upd(PC3, T1, 1);
    look(PC3, 1, 1, T1, "R5 one-bit taken");
    upd(PC3, T1, 0);
    look(PC3, 1, 0, 0, "R5 one-bit flips on one not-taken");
    upd(PC3, T1, 1);
    look(PC3, 1, 1, T1, "R5 one-bit flips back");

    // loops
    runLoop(32'h4000_0020, 32'h4000_0000, m);
    checks++;
    if (m != 2) begin
      errors++;
      $display("FAIL R9 one-bit loop mispredictions got %0d expected 2", m);
    end
    twoBitMode = 1'b1;
    runLoop(32'h5000_0024, 32'h5000_0000, m);
    checks++;
    if (m != 1) begin
      errors++;
      $display("FAIL R9 two-bit loop mispredictions got %0d expected 1", m);
    end

    @(posedge clk); #1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule